// File: doc/BRIEF.md
# Clock Mode and Source Controller

This block decides which clock feeds a small controller's bus and which clock serves as reference for its frequency-locked loop. Software writes a control register holding an oscillator-on bit, a 3-bit reference-divide exponent, a loop-reference select and a bus-source select. From these four fields the block derives one of three operating modes:

- internal-reference engaged: the loop locks to the internal slow clock, and the bus runs from the digitally controlled oscillator (DCO);
- external-reference engaged: the loop locks to the divided crystal clock, and the bus still runs from the DCO;
- bypassed-external: the DCO is off and the bus runs directly from the crystal clock.

The block drives the DCO enable, the oscillator enable and the loop-reference select. It also produces the divided reference as a one-cycle tick in the crystal clock domain. The bus clock comes from a glitch-free two-input switch between the DCO clock and the crystal clock. A lock-status input is watched for both edges, and each edge sets its own write-one-to-clear flag with its own interrupt enable. If the crystal monitor reports a failure while a mode depends on the crystal, the controller falls back to internal-reference engaged and latches a sticky failure flag.

Top module: `clkmode_ctrl`

## Requirements
- R1: On a synchronous reset the control register (address 0) and the status register (address 1) read 0x00, `mode_o` is 0 (internal-reference engaged), `dco_en` is 1, `fll_ref_ext` is 0, `irq` is 0, and `bus_clk` follows `dco_clk`.
- R2: Control register layout at address 0: bit 0 is oscillator-on, bits 3:1 are the divide exponent, bit 4 is reference-external, and bit 5 is bus-from-oscillator. The register reads back as written. `osc_en` equals bit 0. With bit 0 clear, the mode stays 0 whatever bits 4 and 5 hold.
- R3: With bits 0 and 4 set and bit 5 clear, `mode_o` is 1 (external-reference engaged), `fll_ref_ext` is 1, `dco_en` stays 1, and `bus_clk` follows `dco_clk`.
- R4: With bits 0 and 5 set, `mode_o` is 2 (bypassed-external) whatever bit 4 holds. In this mode `dco_en` is 0 and, once the switch settles, `bus_clk` follows `osc_clk`.
- R5: The bus switch never enables both sources at once. A source is dropped on its own falling edge before the other is enabled through a two-flop synchronizer.
- R6: When `osc_fail` is high at a clock edge while `mode_o` is nonzero, control bits 0, 4 and 5 clear at that edge, the mode returns to 0, and status bit 2 sets. Status bit 2 stays set until written with 1. When `osc_fail` is high in mode 0, nothing changes.
- R7: A rising edge of `lock_in` sets status bit 0, and a falling edge sets status bit 1. Status bit 7 reads the current `lock_in`.
- R8: While `osc_en` is 1, `ref_tick` is high for one `osc_clk` cycle out of every 2^N, where N is the divide exponent (0 to 7). For N = 0 it is high on every cycle.
- R9: Writing 1 to status bits 0, 1 or 2 clears them, and writing 0 leaves them unchanged. Status bits 4 and 5 are read/write enables for bits 0 and 1. `irq` is (bit0 AND bit4) OR (bit1 AND bit5). A flag set and a clear in the same cycle leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst | input | 1 | Synchronous active-high reset, seen by all domains |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data, combinational |
| lock_in | input | 1 | Loop lock status, synchronous to clk |
| osc_fail | input | 1 | Crystal monitor failure, synchronous to clk |
| dco_clk | input | 1 | DCO clock |
| osc_clk | input | 1 | Crystal oscillator clock |
| mode_o | output | 2 | Current mode: 0 internal-engaged, 1 external-engaged, 2 bypassed |
| osc_en | output | 1 | Crystal oscillator enable |
| dco_en | output | 1 | DCO enable |
| fll_ref_ext | output | 1 | Loop reference select, 1 = divided crystal |
| ref_tick | output | 1 | Divided reference pulse in the osc_clk domain |
| bus_clk | output | 1 | Glitch-free switched bus clock |
| irq | output | 1 | Lock-change interrupt request |

## Verification
The properties assume that `lock_in` and `osc_fail` already belong to the `clk` domain. They also assume that the divide exponent and the bus-source select are held steady for several cycles of the slower source clock after each write, because the crystal-domain logic samples them without a handshake. The stimulus changes both inputs only one time unit after a `clk` rising edge, and it waits a dozen crystal cycles after every control write before it measures tick counts or compares `bus_clk`. The stimulus keeps reset asserted for several cycles of both source clocks so that each switch chain starts in its reset state.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
    localparam int REG_W = 8;
    localparam int DIV_W = 3;
    localparam int CNT_W = (1 << DIV_W) - 1;

    typedef enum logic [1:0] {
        MODE_INT = 2'd0,
        MODE_EXT = 2'd1,
        MODE_BYP = 2'd2
    } clk_mode_e;

    typedef struct packed {
        logic             bus_osc;
        logic             ref_ext;
        logic [DIV_W-1:0] div;
        logic             osc_on;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic clk_mode_e decode_mode(ctrl_t c);
        if (c.osc_on && c.bus_osc)      return MODE_BYP;
        else if (c.osc_on && c.ref_ext) return MODE_EXT;
        else                            return MODE_INT;
    endfunction
endpackage

// File: rtl/clkmode_regs.sv
module clkmode_regs
    import clkmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             lock_in,
    input  logic             osc_fail,
    output ctrl_t            ctrl,
    output clk_mode_e        mode,
    output logic             irq
);
    logic lock_q, f_on, f_off, f_fail, ie_on, ie_off;
    logic wr_ctrl, wr_stat, lock_rise, lock_fall, fail_hit;

    assign mode      = decode_mode(ctrl);
    assign wr_ctrl   = wr_en && !wr_addr;
    assign wr_stat   = wr_en && wr_addr;
    assign lock_rise = lock_in && !lock_q;
    assign lock_fall = !lock_in && lock_q;
    assign fail_hit  = osc_fail && (mode != MODE_INT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            lock_q <= 1'b0;
            f_on   <= 1'b0;
            f_off  <= 1'b0;
            f_fail <= 1'b0;
            ie_on  <= 1'b0;
            ie_off <= 1'b0;
        end else begin
            lock_q <= lock_in;
            if (fail_hit) begin
                ctrl.osc_on  <= 1'b0;
                ctrl.ref_ext <= 1'b0;
                ctrl.bus_osc <= 1'b0;
                if (wr_ctrl) ctrl.div <= wr_data[DIV_W:1];
            end else if (wr_ctrl) begin
                ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
            end
            if (wr_stat) begin
                ie_on  <= wr_data[4];
                ie_off <= wr_data[5];
            end
            f_on   <= lock_rise || (f_on   && !(wr_stat && wr_data[0]));
            f_off  <= lock_fall || (f_off  && !(wr_stat && wr_data[1]));
            f_fail <= fail_hit  || (f_fail && !(wr_stat && wr_data[2]));
        end
    end

    assign irq = (f_on && ie_on) || (f_off && ie_off);

    always_comb begin
        rd_data = '0;
        if (rd_addr) begin
            rd_data[0] = f_on;
            rd_data[1] = f_off;
            rd_data[2] = f_fail;
            rd_data[4] = ie_on;
            rd_data[5] = ie_off;
            rd_data[7] = lock_in;
        end else begin
            rd_data[CTRL_W-1:0] = ctrl;
        end
    end

    p_fail_fallback_r6: assert property (@(posedge clk) disable iff (rst)
        (osc_fail && mode != MODE_INT) |=> (mode == MODE_INT && f_fail));

    p_fail_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (osc_fail && mode == MODE_INT && !wr_en) |=> $stable(ctrl));

    p_rise_irq_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(lock_in) && ie_on && !wr_en) |=> irq);

    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wr_data[0] && !lock_rise) |=> !f_on);
endmodule

// File: rtl/clkmode_refdiv.sv
module clkmode_refdiv
    import clkmode_pkg::*;
(
    input  logic             osc_clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = {CNT_W{1'b1}} >> (CNT_W - int'(div));
    assign tick = en && (cnt >= lim);

    always_ff @(posedge osc_clk) begin
        if (rst || !en)      cnt <= '0;
        else if (cnt >= lim) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    p_tick_gap_r8: assert property (@(posedge osc_clk) disable iff (rst)
        (tick && div != '0 && $stable(div) && $stable(en)) |=> !tick);
endmodule

// File: rtl/clkmode_gfmux.sv
module clkmode_gfmux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel_b,
    output logic clk_out
);
    logic a1, a2, b1, b2;

    always_ff @(negedge clk_a) begin
        if (rst) begin
            a1 <= 1'b1;
            a2 <= 1'b1;
        end else begin
            a1 <= !sel_b && !b2;
            a2 <= a1;
        end
    end

    always_ff @(negedge clk_b) begin
        if (rst) begin
            b1 <= 1'b0;
            b2 <= 1'b0;
        end else begin
            b1 <= sel_b && !a2;
            b2 <= b1;
        end
    end

    assign clk_out = (clk_a && a2) || (clk_b && b2);

    p_one_source_r5: assert property (@(posedge clk_a) disable iff (rst)
        $onehot0({a2, b2}));

    p_one_source_b_r5: assert property (@(posedge clk_b) disable iff (rst)
        $onehot0({a2, b2}));
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             lock_in,
    input  logic             osc_fail,
    input  logic             dco_clk,
    input  logic             osc_clk,
    output logic [1:0]       mode_o,
    output logic             osc_en,
    output logic             dco_en,
    output logic             fll_ref_ext,
    output logic             ref_tick,
    output logic             bus_clk,
    output logic             irq
);
    ctrl_t     ctrl;
    clk_mode_e mode;

    clkmode_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .lock_in  (lock_in),
        .osc_fail (osc_fail),
        .ctrl     (ctrl),
        .mode     (mode),
        .irq      (irq)
    );

    assign mode_o      = mode;
    assign osc_en      = ctrl.osc_on;
    assign dco_en      = (mode != MODE_BYP);
    assign fll_ref_ext = (mode == MODE_EXT);

    clkmode_refdiv u_refdiv (
        .osc_clk (osc_clk),
        .rst     (rst),
        .en      (ctrl.osc_on),
        .div     (ctrl.div),
        .tick    (ref_tick)
    );

    clkmode_gfmux u_busmux (
        .clk_a   (dco_clk),
        .clk_b   (osc_clk),
        .rst     (rst),
        .sel_b   (mode == MODE_BYP),
        .clk_out (bus_clk)
    );

    p_byp_dco_off_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> (!dco_en && osc_en));
endmodule

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, dco_clk = 0, osc_clk = 0;
    logic       rst = 1, wr_en = 0, wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic       lock_in = 0, osc_fail = 0;
    logic [7:0] rd_data;
    logic [1:0] mode_o;
    logic       osc_en, dco_en, fll_ref_ext, ref_tick, bus_clk, irq;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #4 dco_clk = ~dco_clk;
    initial begin #2; forever begin osc_clk = ~osc_clk; #8; end end

    clkmode_ctrl u0 (.*);

    typedef struct {
        int    kind;
        int    exp;
        int    act;
        string req;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    function automatic int observe(item_t it);
        case (it.kind)
            0: return int'(rd_data);
            1: return int'(mode_o);
            2: return int'(dco_en);
            3: return int'(fll_ref_ext);
            4: return int'(irq);
            5: return int'(bus_clk == (it.exp != 0 ? osc_clk : dco_clk));
            6: return int'(osc_en);
            default: return it.act;
        endcase
    endfunction

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int a, e;
            it = q.pop_front();
            a = observe(it);
            e = (it.kind == 5) ? 1 : it.exp;
            n_chk++;
            if (a != e) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, a, e);
            end
        end
    end

    task automatic push(int kind, int exp, string req, int act = 0);
        item_t it;
        it.kind = kind; it.exp = exp; it.act = act; it.req = req;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic rd(bit a, int exp, string req);
        rd_addr = a;
        push(0, exp, req);
    endtask

    task automatic wr(bit a, int d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = 8'(d);
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic settle();
        repeat (12) @(posedge osc_clk);
        @(posedge clk); #1;
    endtask

    task automatic bus_follow(bit osc, string req);
        for (int i = 0; i < 4; i++) push(5, osc, req);
    endtask

    task automatic count_ticks(int cycles, int exp, string req);
        int c = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge osc_clk);
            if (ref_tick) c++;
        end
        push(7, exp, req, c);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (6) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        rd(0, 8'h00, "R1");
        rd(1, 8'h00, "R1");
        push(1, 0, "R1");
        push(2, 1, "R1");
        push(3, 0, "R1");
        push(4, 0, "R1");
        bus_follow(0, "R1");

        // R2 ref-external without oscillator stays internal
        wr(0, 8'h10);
        push(1, 0, "R2");
        push(6, 0, "R2");
        rd(0, 8'h10, "R2");

        // R3 external engaged, divide exponent 3
        wr(0, 8'h17);
        push(1, 1, "R3");
        push(3, 1, "R3");
        push(2, 1, "R3");
        push(6, 1, "R2");
        rd(0, 8'h17, "R2");
        settle();
        bus_follow(0, "R3");
        // R8 divider
        count_ticks(64, 8, "R8");
        wr(0, 8'h11);
        settle();
        count_ticks(16, 16, "R8");
        wr(0, 8'h1F);
        settle();
        count_ticks(256, 2, "R8");

        // R4 bypassed, bit 4 also set
        wr(0, 8'h31);
        push(1, 2, "R4");
        push(2, 0, "R4");
        push(3, 0, "R4");
        settle();
        bus_follow(1, "R4");
        bus_follow(1, "R5");

        // R5 back to DCO cleanly
        wr(0, 8'h00);
        settle();
        bus_follow(0, "R5");

        // R6 oscillator failure in bypass
        wr(0, 8'h23);
        settle();
        push(1, 2, "R6");
        @(posedge clk); #1 osc_fail = 1;
        @(posedge clk); #1 osc_fail = 0;
        push(1, 0, "R6");
        rd(0, 8'h02, "R6");
        rd(1, 8'h04, "R6");
        settle();
        bus_follow(0, "R6");
        wr(1, 8'h00);
        rd(1, 8'h04, "R9");
        wr(1, 8'h04);
        rd(1, 8'h00, "R9");
        // R6 failure in internal mode ignored
        @(posedge clk); #1 osc_fail = 1;
        @(posedge clk); #1 osc_fail = 0;
        rd(1, 8'h00, "R6");
        rd(0, 8'h02, "R6");

        // R7 / R9 lock edges and interrupts
        wr(1, 8'h10);
        @(posedge clk); #1 lock_in = 1;
        @(posedge clk); #1;
        rd(1, 8'h91, "R7");
        push(4, 1, "R9");
        wr(1, 8'h11);
        rd(1, 8'h90, "R9");
        push(4, 0, "R9");
        @(posedge clk); #1 lock_in = 0;
        @(posedge clk); #1;
        rd(1, 8'h12, "R7");
        push(4, 0, "R9");
        wr(1, 8'h30);
        rd(1, 8'h32, "R9");
        push(4, 1, "R9");
        wr(1, 8'h32);
        rd(1, 8'h30, "R9");
        push(4, 0, "R9");

        // R9 set wins over same-cycle clear
        @(posedge clk); #1;
        lock_in = 1; wr_en = 1; wr_addr = 1; wr_data = 8'h31;
        @(posedge clk); #1 wr_en = 0;
        rd(1, 8'hB1, "R9");

        // R1 reset again
        @(posedge clk); #1 rst = 1;
        repeat (6) @(posedge clk);
        #1 rst = 0; lock_in = 0;
        rd(0, 8'h00, "R1");
        rd(1, 8'h00, "R1");

        @(negedge clk); #1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule